// File: doc/BRIEF.md
# LPC Memory Target Interface

This block is the target end of a four-bit Low Pin Count bus for a small byte-wide memory. Each rising clock edge it samples the framing input `frame_n` and the nibble on `lad_in`. A frame carries a start nibble, a cycle-type nibble, a 32-bit address sent as eight nibbles most significant first, write data when the frame is a write, and a turnaround. The target then answers with wait nibbles until the backend has finished, and returns two data nibbles on a read. It ends the frame with its own turnaround. The backend is a synchronous request/ready port. The memory array behind that port is outside the block.

The controller is a single state machine. Its states are `ST_IDLE` (waiting for a start), `ST_CTYPE` (cycle type), `ST_ADDR` (address nibbles), `ST_WDATA` (write data), `ST_HTAR` (host turnaround), `ST_SYNC` (wait nibbles), `ST_RDATA` (read data), `ST_TTAR` (target turnaround) and `ST_SKIP` (frame not claimed).
- Any state moves to `ST_CTYPE` when `frame_n` is low with the start nibble on the bus, and to `ST_IDLE` when `frame_n` is low with any other nibble.
- With `frame_n` high, the state machine moves as follows:
  - `ST_CTYPE` moves to `ST_ADDR` for a read or write code, and to `ST_SKIP` for any other code.
  - `ST_ADDR` moves after its last nibble: to `ST_SKIP` when the address is outside the window, otherwise to `ST_WDATA` for a write or `ST_HTAR` for a read.
  - `ST_WDATA` moves to `ST_HTAR` after the high nibble.
  - `ST_HTAR` moves to `ST_SYNC` after its last cycle.
  - `ST_SYNC` moves to `ST_RDATA` (read) or `ST_TTAR` (write) once the ready nibble has been driven.
  - `ST_RDATA` moves to `ST_TTAR` after two nibbles.
  - `ST_TTAR` moves to `ST_IDLE` after its last cycle.
  - `ST_IDLE` and `ST_SKIP` hold.

A system integrates the block by tying `lad_out`/`lad_oe` and `lad_in` to a tri-state pad. The two resets are combined so that either one clears the block.

Top module: `lpc_mem_target`

## Requirements
- R1: While `rst_if_n` or `rst_cpu_n` is low, `lad_oe` and `be_req` are 0 in that same cycle. After release the block is idle, and the next read frame completes normally.
- R2: A frame opens only when `frame_n` is sampled low with `lad_in` = 4'b0000. When `frame_n` is low with any other nibble, no frame opens. The target never drives LAD during the start, cycle-type or address cycles.
- R3: Cycle type 4'b0100 selects a read and 4'b0110 selects a write. Any other code makes the target ignore the frame until the next start: no LAD drive and no backend request.
- R4: The address is eight nibbles, most significant first. A frame is claimed only when address bits 31:8 equal 24'hFFFFFF (the default window). The backend receives address bits 7:0. An unclaimed frame is never driven and issues no backend request.
- R5: The target leaves LAD undriven for the two host turnaround cycles. It then drives 4'b0101 for at least WAIT_CYC (3) cycles and for as long as the backend has not answered. After that it drives exactly one 4'b0000.
- R6: On a read, the two cycles after the 4'b0000 carry the backend byte, bits 3:0 first and then bits 7:4.
- R7: At the end of a frame the target drives 4'b1111 for one cycle, stops driving in the next cycle, and is then idle.
- R8: On a write, the nibble after the address gives data bits 3:0 and the next nibble gives bits 7:4. The backend sees a write request with that byte and address, held stable until `be_ready`.
- R9: If `frame_n` is sampled low with a non-start nibble during a frame, LAD is released from the next cycle and the target is idle. If it is sampled low with 4'b0000, a new frame opens at once.
- R10: A write is committed to the backend when its high data nibble arrives. An abort after that point does not cancel it.
- R11: While idle with `frame_n` high, `lad_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_if_n | input | 1 | Interface reset, active low, asynchronous |
| rst_cpu_n | input | 1 | CPU reset, active low, asynchronous |
| frame_n | input | 1 | Frame marker from host, active low |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Drive enable for lad_out |
| be_req | output | 1 | Backend request, held until be_ready |
| be_we | output | 1 | Backend request is a write |
| be_addr | output | MEM_AW | Backend byte address |
| be_wdata | output | 8 | Backend write byte |
| be_rdata | input | 8 | Backend read byte, valid with be_ready |
| be_ready | input | 1 | Backend completes the request this cycle |

## Verification
A wrong state shows on the pins within one or two cycles. A target stuck outside idle keeps `lad_oe` high after the frame's turnaround, or after an abort. A misplaced address or data nibble counter makes the target answer in the wrong cycle, hand the wrong byte to the backend, or drop the frame. A wait counter or done flag that is wrong shows as fewer than three wait nibbles, or as a ready nibble before the backend has answered. A write wrongly tied to the frame's life shows as memory left unchanged after a late abort.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    // bus code values
    localparam logic [3:0] NIB_START     = 4'b0000;
    localparam logic [3:0] NIB_CT_RD     = 4'b0100;
    localparam logic [3:0] NIB_CT_WR     = 4'b0110;
    localparam logic [3:0] NIB_SYNC_WAIT = 4'b0101;
    localparam logic [3:0] NIB_SYNC_OK   = 4'b0000;
    localparam logic [3:0] NIB_TAR       = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR,
        ST_SYNC,
        ST_RDATA,
        ST_TTAR,
        ST_SKIP
    } lpc_st_e;

endpackage

// File: rtl/lpc_nib_collect.sv
module lpc_nib_collect #(
    parameter int NIBS      = 8,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [3:0]         nib,
    output logic [NIBS*4-1:0]  nxt,
    output logic               last
);
    localparam int W  = NIBS * 4;
    localparam int CW = (NIBS > 1) ? $clog2(NIBS) : 1;

    logic [W-5:0]  held;
    logic [CW-1:0] idx;

    // field value including the nibble on the bus now
    generate
        if (MSB_FIRST) begin : g_msb
            assign nxt = {held, nib};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    held <= '0;
                else if (shift)
                    held <= nxt[W-5:0];
            end
        end else begin : g_lsb
            assign nxt = {nib, held};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    held <= '0;
                else if (shift)
                    held <= nxt[W-1:4];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (shift)
            idx <= last ? '0 : idx + 1'b1;
    end

    assign last = (idx == CW'(NIBS - 1));

endmodule

// File: rtl/lpc_win_decode.sv
module lpc_win_decode #(
    parameter int                BUS_AW   = 32,
    parameter int                MEM_AW   = 8,
    parameter logic [BUS_AW-1:0] WIN_BASE = 32'hFFFF_FF00
) (
    input  logic [BUS_AW-1:0] addr,
    output logic              hit,
    output logic [MEM_AW-1:0] off
);
    // window is aligned on its own size
    assign hit = (addr[BUS_AW-1:MEM_AW] == WIN_BASE[BUS_AW-1:MEM_AW]);
    assign off = addr[MEM_AW-1:0];

endmodule

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
    parameter int WAIT_CYC = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    output logic [$clog2(WAIT_CYC+1)-1:0]  cnt
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    // counts cycles spent in the wait phase, saturating at the minimum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != CW'(WAIT_CYC))
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/lpc_be_port.sv
module lpc_be_port #(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_rd,
    input  logic              issue_wr,
    input  logic              cancel_rd,
    input  logic              clr_done,
    input  logic [MEM_AW-1:0] addr_in,
    input  logic [7:0]        wdata_in,
    output logic              be_req,
    output logic              be_we,
    output logic [MEM_AW-1:0] be_addr,
    output logic [7:0]        be_wdata,
    input  logic [7:0]        be_rdata,
    input  logic              be_ready,
    output logic              done,
    output logic [7:0]        rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_req   <= 1'b0;
            be_we    <= 1'b0;
            be_addr  <= '0;
            be_wdata <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            if (clr_done)
                done <= 1'b0;
            if (be_req && be_ready) begin
                be_req <= 1'b0;
                done   <= 1'b1;
                if (!be_we)
                    rdata <= be_rdata;
            end else if (cancel_rd && be_req && !be_we) begin
                // reads have no side effect; writes survive aborts
                be_req <= 1'b0;
            end
            if (!be_req && (issue_rd || issue_wr)) begin
                be_req  <= 1'b1;
                be_we   <= issue_wr;
                be_addr <= addr_in;
                done    <= 1'b0;
                if (issue_wr)
                    be_wdata <= wdata_in;
            end
        end
    end

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int                    ADDR_NIB = 8,
    parameter int                    TAR_CYC  = 2,
    parameter int                    WAIT_CYC = 3,
    parameter int                    MEM_AW   = 8,
    parameter logic [ADDR_NIB*4-1:0] WIN_BASE = 32'hFFFF_FF00
) (
    input  logic              clk,
    input  logic              rst_if_n,
    input  logic              rst_cpu_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              be_req,
    output logic              be_we,
    output logic [MEM_AW-1:0] be_addr,
    output logic [7:0]        be_wdata,
    input  logic [7:0]        be_rdata,
    input  logic              be_ready
);
    localparam int BUS_AW = ADDR_NIB * NIB_W;
    localparam int PHW    = (TAR_CYC > 2) ? $clog2(TAR_CYC) : 1;
    localparam int SCW    = $clog2(WAIT_CYC + 1);

    logic              rst_n;
    lpc_st_e           st, st_nx;
    logic [PHW-1:0]    ph;
    logic              dir_wr;
    logic [MEM_AW-1:0] off_q;

    logic              start_seen, abort_seen;
    logic              a_shift, a_last, d_shift, d_last;
    logic [BUS_AW-1:0] a_nxt;
    logic [BYTE_W-1:0] d_nxt;
    logic              win_hit;
    logic [MEM_AW-1:0] win_off;
    logic [SCW-1:0]    sync_cnt;
    logic              waited, sync_ok;
    logic              issue_rd, issue_wr;
    logic              be_done;
    logic [7:0]        rd_byte;
    logic [MEM_AW-1:0] req_addr;

    // either reset deselects the target
    assign rst_n = rst_if_n & rst_cpu_n;

    assign start_seen = !frame_n && (lad_in == NIB_START);
    assign abort_seen = !frame_n;

    assign a_shift  = frame_n && (st == ST_ADDR);
    assign d_shift  = frame_n && (st == ST_WDATA);
    assign issue_rd = a_shift && a_last && win_hit && !dir_wr;
    assign issue_wr = d_shift && d_last;
    assign req_addr = issue_wr ? off_q : win_off;

    assign waited  = (sync_cnt == SCW'(WAIT_CYC));
    assign sync_ok = waited && be_done;

    lpc_nib_collect #(.NIBS(ADDR_NIB), .MSB_FIRST(1'b1)) addr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_seen),
        .shift (a_shift),
        .nib   (lad_in),
        .nxt   (a_nxt),
        .last  (a_last)
    );

    lpc_nib_collect #(.NIBS(BYTE_W / NIB_W), .MSB_FIRST(1'b0)) data_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_seen),
        .shift (d_shift),
        .nib   (lad_in),
        .nxt   (d_nxt),
        .last  (d_last)
    );

    lpc_win_decode #(.BUS_AW(BUS_AW), .MEM_AW(MEM_AW), .WIN_BASE(WIN_BASE)) win_i (
        .addr (a_nxt),
        .hit  (win_hit),
        .off  (win_off)
    );

    lpc_sync_timer #(.WAIT_CYC(WAIT_CYC)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st == ST_SYNC),
        .cnt   (sync_cnt)
    );

    lpc_be_port #(.MEM_AW(MEM_AW)) be_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_rd  (issue_rd),
        .issue_wr  (issue_wr),
        .cancel_rd (abort_seen),
        .clr_done  (start_seen),
        .addr_in   (req_addr),
        .wdata_in  (d_nxt),
        .be_req    (be_req),
        .be_we     (be_we),
        .be_addr   (be_addr),
        .be_wdata  (be_wdata),
        .be_rdata  (be_rdata),
        .be_ready  (be_ready),
        .done      (be_done),
        .rdata     (rd_byte)
    );

    // next state
    always_comb begin
        st_nx = st;
        if (!frame_n) begin
            st_nx = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  st_nx = ST_IDLE;
                ST_CTYPE: st_nx = ((lad_in == NIB_CT_RD) || (lad_in == NIB_CT_WR))
                                  ? ST_ADDR : ST_SKIP;
                ST_ADDR: begin
                    if (a_last) begin
                        if (!win_hit)
                            st_nx = ST_SKIP;
                        else
                            st_nx = dir_wr ? ST_WDATA : ST_HTAR;
                    end
                end
                ST_WDATA: if (d_last) st_nx = ST_HTAR;
                ST_HTAR:  if (ph == PHW'(TAR_CYC - 1)) st_nx = ST_SYNC;
                ST_SYNC:  if (sync_ok) st_nx = dir_wr ? ST_TTAR : ST_RDATA;
                ST_RDATA: if (ph == PHW'(1)) st_nx = ST_TTAR;
                ST_TTAR:  if (ph == PHW'(TAR_CYC - 1)) st_nx = ST_IDLE;
                ST_SKIP:  st_nx = ST_SKIP;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ph     <= '0;
            dir_wr <= 1'b0;
            off_q  <= '0;
        end else begin
            st <= st_nx;
            ph <= (st_nx != st) ? '0 : ph + 1'b1;
            if (st == ST_CTYPE && frame_n)
                dir_wr <= (lad_in == NIB_CT_WR);
            if (a_shift && a_last)
                off_q <= win_off;
        end
    end

    // bus outputs
    always_comb begin
        lad_oe  = 1'b0;
        lad_out = 4'b0000;
        unique case (st)
            ST_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = sync_ok ? NIB_SYNC_OK : NIB_SYNC_WAIT;
            end
            ST_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = ph[0] ? rd_byte[7:4] : rd_byte[3:0];
            end
            ST_TTAR: begin
                if (ph == '0) begin
                    lad_oe  = 1'b1;
                    lad_out = NIB_TAR;
                end
            end
            ST_IDLE, ST_CTYPE, ST_ADDR, ST_WDATA, ST_HTAR, ST_SKIP: begin
                lad_oe  = 1'b0;
                lad_out = 4'b0000;
            end
            default: begin
                lad_oe  = 1'b0;
                lad_out = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/lpc_mem_target_chk.sv
module lpc_mem_target_chk
    import lpc_tgt_pkg::*;
#(
    parameter int WAIT_CYC = 3,
    parameter int MEM_AW   = 8
) (
    input logic                          clk,
    input logic                          rst_if_n,
    input logic                          rst_cpu_n,
    input logic                          frame_n,
    input logic [3:0]                    lad_in,
    input logic [3:0]                    lad_out,
    input logic                          lad_oe,
    input logic                          be_req,
    input logic                          be_we,
    input logic                          be_ready,
    input logic [MEM_AW-1:0]             be_addr,
    input logic [7:0]                    be_wdata,
    input lpc_st_e                       st,
    input logic [$clog2(WAIT_CYC+1)-1:0] sync_cnt
);
    logic rn;
    assign rn = rst_if_n & rst_cpu_n;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rn |-> (!lad_oe && !be_req));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rn)
        (st == ST_IDLE) |-> !lad_oe);

    // R2
    start_open_chk: assert property (@(posedge clk) disable iff (!rn)
        (!frame_n && lad_in == NIB_START) |=> (st == ST_CTYPE && !lad_oe));

    // R9
    abort_release_chk: assert property (@(posedge clk) disable iff (!rn)
        (!frame_n && lad_in != NIB_START) |=> (st == ST_IDLE && !lad_oe));

    // R5
    sync_min_chk: assert property (@(posedge clk) disable iff (!rn)
        (st == ST_SYNC && lad_oe && lad_out == NIB_SYNC_OK) |-> (int'(sync_cnt) >= WAIT_CYC));

    // R7
    ttar_release_chk: assert property (@(posedge clk) disable iff (!rn)
        (st == ST_TTAR && lad_oe) |=> !lad_oe);

    // R8 R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rn)
        (be_req && be_we && !be_ready) |=>
            (be_req && be_we && $stable(be_addr) && $stable(be_wdata)));

endmodule

bind lpc_mem_target lpc_mem_target_chk #(.WAIT_CYC(WAIT_CYC), .MEM_AW(MEM_AW)) chk_i (
    .clk       (clk),
    .rst_if_n  (rst_if_n),
    .rst_cpu_n (rst_cpu_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .be_req    (be_req),
    .be_we     (be_we),
    .be_ready  (be_ready),
    .be_addr   (be_addr),
    .be_wdata  (be_wdata),
    .st        (st),
    .sync_cnt  (sync_cnt)
);

// File: tb/lpc_mem_target_tb_top.sv
module lpc_mem_target_tb_top;

    localparam int WAITN = 3;

    logic       clk = 1'b0;
    logic       rst_if_n = 1'b1;
    logic       rst_cpu_n = 1'b1;
    logic       frame_n = 1'b1;
    logic [3:0] lad_in = 4'hF;
    logic [3:0] lad_out;
    logic       lad_oe;
    logic       be_req, be_we, be_ready;
    logic [7:0] be_addr, be_wdata, be_rdata;

    logic [7:0] mem [256];
    int         be_lat = 0;
    int         bcnt = 0;
    bit         req_seen = 1'b0;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    lpc_mem_target dut_i (
        .clk(clk), .rst_if_n(rst_if_n), .rst_cpu_n(rst_cpu_n),
        .frame_n(frame_n), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
        .be_req(be_req), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_rdata(be_rdata), .be_ready(be_ready)
    );

    // backend model: byte array answering after be_lat cycles
    assign be_ready = be_req && (bcnt >= be_lat);
    assign be_rdata = mem[be_addr];

    always @(posedge clk) begin
        if (be_req) req_seen <= 1'b1;
        if (!be_req) bcnt <= 0;
        else if (be_ready) begin
            bcnt <= 0;
            if (be_we) mem[be_addr] <= be_wdata;
        end else bcnt <= bcnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bus cycle: sample outputs of the previous edge, then drive
    task automatic step(input logic f, input logic [3:0] l, output logic o, output logic [3:0] v);
        @(negedge clk);
        o = lad_oe;
        v = lad_out;
        frame_n = f;
        lad_in = l;
    endtask

    task automatic idle_cycles(input int n, input string req);
        logic o; logic [3:0] v;
        for (int i = 0; i < n; i++) begin
            step(1'b1, 4'hF, o, v);
            chk(!o, req, o, 0);
        end
    endtask

    task automatic send_hdr(input logic [3:0] ct, input logic [31:0] a);
        logic o; logic [3:0] v;
        step(1'b0, 4'h0, o, v);
        step(1'b1, ct, o, v);
        for (int i = 7; i >= 0; i--) begin
            step(1'b1, a[i*4 +: 4], o, v);
            chk(!o, "R2 silent in header", o, 0);
        end
    endtask

    task automatic host_tar();
        logic o; logic [3:0] v;
        for (int i = 0; i < 2; i++) begin
            step(1'b1, 4'hF, o, v);
            chk(!o, "R5 host tar undriven", o, 0);
        end
    endtask

    task automatic wait_sync(output int nshort, output bit got);
        logic o; logic [3:0] v;
        nshort = 0;
        got = 1'b0;
        for (int k = 0; k < 80 && !got; k++) begin
            step(1'b1, 4'hF, o, v);
            if (!o) begin
                chk(1'b0, "R5 sync driven", o, 1);
                k = 80;
            end else if (v == 4'b0101) nshort++;
            else if (v == 4'b0000) got = 1'b1;
            else begin
                chk(1'b0, "R5 sync code", v, 5);
                k = 80;
            end
        end
        chk(got, "R5 ready nibble", got, 1);
        chk(nshort >= WAITN, "R5 min wait", nshort, WAITN);
    endtask

    task automatic end_tar();
        logic o; logic [3:0] v;
        step(1'b1, 4'hF, o, v);
        chk(o && v == 4'hF, "R7 tar drive", {o, v}, 5'h1F);
        step(1'b1, 4'hF, o, v);
        chk(!o, "R7 tar release", o, 0);
        step(1'b1, 4'hF, o, v);
        chk(!o, "R7 idle after", o, 0);
    endtask

    task automatic do_read(input logic [31:0] a, input int lat, input logic [7:0] exp);
        logic o; logic [3:0] v; int ns; bit got;
        be_lat = lat;
        send_hdr(4'b0100, a);
        host_tar();
        wait_sync(ns, got);
        if (lat > WAITN + 4) chk(ns > WAITN, "R5 wait extended", ns, WAITN + 1);
        step(1'b1, 4'hF, o, v);
        chk(o && v == exp[3:0], "R6 low nibble", v, exp[3:0]);
        step(1'b1, 4'hF, o, v);
        chk(o && v == exp[7:4], "R6 high nibble", v, exp[7:4]);
        end_tar();
    endtask

    task automatic do_write(input logic [31:0] a, input logic [7:0] d, input int lat);
        logic o; logic [3:0] v; int ns; bit got;
        be_lat = lat;
        send_hdr(4'b0110, a);
        step(1'b1, d[3:0], o, v);
        step(1'b1, d[7:4], o, v);
        host_tar();
        wait_sync(ns, got);
        if (lat > WAITN + 4) chk(ns > WAITN, "R5 write wait extended", ns, WAITN + 1);
        end_tar();
        chk(mem[a[7:0]] == d, "R8 write landed", mem[a[7:0]], d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!lad_oe && !be_req, "R1 reset state", {lad_oe, be_req}, 0);
        idle_cycles(4, "R11 standby undriven");
    endtask

    task automatic t_reads();
        do_read(32'hFFFF_FF21, 0, mem[8'h21]);
        do_read(32'hFFFF_FF9C, 12, mem[8'h9C]);
    endtask

    task automatic t_writes();
        do_write(32'hFFFF_FF10, 8'hA5, 2);
        do_read(32'hFFFF_FF10, 1, 8'hA5);
        do_write(32'hFFFF_FFE3, 8'h3C, 10);
        do_read(32'hFFFF_FFE3, 0, 8'h3C);
    endtask

    task automatic t_bad_ctype();
        logic o; logic [3:0] v;
        req_seen = 1'b0;
        step(1'b0, 4'h0, o, v);
        step(1'b1, 4'b0010, o, v);
        for (int i = 0; i < 14; i++) begin
            step(1'b1, 4'h0, o, v);
            chk(!o, "R3 unknown type silent", o, 0);
        end
        chk(!req_seen, "R3 unknown type no request", req_seen, 0);
        do_read(32'hFFFF_FF05, 0, mem[8'h05]);
    endtask

    task automatic t_out_window();
        logic o; logic [3:0] v;
        req_seen = 1'b0;
        send_hdr(4'b0100, 32'h1234_5621);
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 4'hF, o, v);
            chk(!o, "R4 unclaimed silent", o, 0);
        end
        chk(!req_seen, "R4 unclaimed no request", req_seen, 0);
    endtask

    task automatic t_bad_start();
        logic o; logic [3:0] v;
        logic [31:0] a;
        a = 32'hFFFF_FF40;
        req_seen = 1'b0;
        step(1'b0, 4'h3, o, v);
        step(1'b1, 4'b0100, o, v);
        for (int i = 7; i >= 0; i--) step(1'b1, a[i*4 +: 4], o, v);
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 4'hF, o, v);
            chk(!o, "R2 no frame without start", o, 0);
        end
        chk(!req_seen, "R2 no request without start", req_seen, 0);
    endtask

    task automatic t_abort_addr();
        logic o; logic [3:0] v;
        req_seen = 1'b0;
        step(1'b0, 4'h0, o, v);
        step(1'b1, 4'b0100, o, v);
        step(1'b1, 4'hF, o, v);
        step(1'b1, 4'hF, o, v);
        step(1'b0, 4'hF, o, v);
        idle_cycles(3, "R9 abort releases");
        chk(!req_seen, "R9 abort mid address no request", req_seen, 0);
        // abort carrying a start opens a fresh frame at once
        step(1'b0, 4'h0, o, v);
        step(1'b1, 4'b0110, o, v);
        step(1'b1, 4'hF, o, v);
        do_read(32'hFFFF_FF77, 0, mem[8'h77]);
    endtask

    task automatic t_abort_write_tar();
        logic o; logic [3:0] v;
        be_lat = 6;
        send_hdr(4'b0110, 32'hFFFF_FF5A);
        step(1'b1, 4'h9, o, v);
        step(1'b1, 4'h6, o, v);
        step(1'b1, 4'hF, o, v);
        step(1'b0, 4'hF, o, v);
        step(1'b1, 4'hF, o, v);
        chk(!o, "R9 release after tar abort", o, 0);
        idle_cycles(12, "R9 idle after abort");
        chk(mem[8'h5A] == 8'h69, "R10 write survives abort", mem[8'h5A], 8'h69);
    endtask

    task automatic t_reset_mid();
        int ns;
        bit got;
        logic o; logic [3:0] v;
        be_lat = 20;
        send_hdr(4'b0100, 32'hFFFF_FF30);
        host_tar();
        step(1'b1, 4'hF, o, v);
        step(1'b1, 4'hF, o, v);
        chk(o, "R5 sync under way", o, 1);
        @(negedge clk);
        rst_cpu_n = 1'b0;
        #1;
        chk(!lad_oe && !be_req, "R1 cpu reset releases", {lad_oe, be_req}, 0);
        repeat (2) @(negedge clk);
        rst_cpu_n = 1'b1;
        rst_if_n = 1'b0;
        #1;
        chk(!lad_oe && !be_req, "R1 interface reset", {lad_oe, be_req}, 0);
        @(negedge clk);
        rst_if_n = 1'b1;
        idle_cycles(2, "R1 idle after reset");
        do_read(32'hFFFF_FF30, 0, mem[8'h30]);
        ns = 0;
        got = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        #1;
        rst_if_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_if_n = 1'b1;
        t_reset();
        t_reads();
        t_writes();
        t_bad_ctype();
        t_out_window();
        t_bad_start();
        t_abort_addr();
        t_abort_write_tar();
        t_reset_mid();
        idle_cycles(3, "R11 standby end");
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule